// File: doc/BRIEF.md
# Dual-Mode CORDIC Givens Rotator

This block is the rotation engine of a one-sided Jacobi orthogonalisation unit. One unrolled, fully pipelined CORDIC datapath serves two jobs. In vectoring mode it takes the two angle operands of a column pair: `in_a` is the difference of squared norms (norm of column j minus norm of column i) and `in_b` is twice their inner product. From these it computes the Jacobi angle θ = ½·atan(in_b / in_a) and compares |θ| against a threshold, which decides whether the pair needs to be rotated. In rotating mode it streams element pairs (one element of column i, one of column j) through the same stages. It applies the Givens rotation by the held angle, or passes the elements through untouched when the last evaluation found no rotation to be needed. The data columns and the accumulated V columns use the same path, so the V columns are rotated only when the data pair was.

Every micro-rotation shift is fixed wiring, with one stage per iteration. The core accepts one input per clock in either mode and mixes the two modes freely. The CORDIC gain is removed by a single constant multiply at the output. Angles use units of 2^-15 rad.

Top module: `givrot_core`

## Requirements
- R1: During and after reset, with no input yet given, `out_valid` and `out_rot` are 0 and `out_angle` is 0.
- R2: Every input accepted with `in_valid` high produces exactly one output with `out_valid` high, ITER+2 = 18 clocks later, in issue order. A new input is accepted every clock.
- R3: A vectoring result (`in_vec`=1) reports `out_angle` = ½·atan(in_b/in_a)·2^15 (principal atan, signed two's complement) within 16 units.
- R4: A negative `in_a` gives the same principal-value angle as R3. `in_a`=0 with nonzero `in_b` gives ±π/4 (±25736 units) with the sign of `in_b`, so |`out_angle`| never exceeds about 25736.
- R5: A vectoring input with `in_b`=0 reports an angle of exactly 0.
- R6: A vectoring result sets `out_rot` to 1 exactly when |`out_angle`| ≥ `thresh` (unsigned, same units). `thresh`=0 therefore always sets it.
- R7: Vectoring results carry 0 on `out_a` and `out_b`. `out_angle` and `out_rot` change only on a vectoring result and hold until the next one.
- R8: A rotating input (`in_vec`=0) entering while the held flag is 1 yields `out_a` = a·cosθ − b·sinθ and `out_b` = a·sinθ + b·cosθ within 6 LSB, where a=`in_a`, b=`in_b` and θ is the held angle.
- R9: A rotating input entering while the held flag is 0 leaves the core with `out_a`=`in_a` and `out_b`=`in_b` exactly.
- R10: Rotating all element pairs of a column pair by the angle evaluated from that pair's norms and inner product leaves columns whose inner product is below 0.005 of the product of their lengths.
- R11: A rotating input uses the angle and flag held when it enters. A vectoring input still in flight does not affect it, and rotating inputs issued after that vectoring result leaves use the new angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input present this cycle |
| in_vec | input | 1 | 1 = vectoring (evaluate angle), 0 = rotating (apply to element pair) |
| in_a | input | 18 | Signed: norm difference (vectoring) or element of column i (rotating) |
| in_b | input | 18 | Signed: twice the inner product (vectoring) or element of column j (rotating) |
| thresh | input | 17 | Unsigned angle threshold, 2^-15 rad per unit, sampled as a vectoring result leaves |
| out_valid | output | 1 | Result present this cycle |
| out_vec | output | 1 | Result is from a vectoring input |
| out_a | output | 18 | Signed rotated element of column i (0 for vectoring results) |
| out_b | output | 18 | Signed rotated element of column j (0 for vectoring results) |
| out_angle | output | 18 | Signed held half angle, 2^-15 rad per unit |
| out_rot | output | 1 | Held decision: 1 = rotation required |

## Verification
The bench aims at the angle corners. A negative denominator checks that the pre-negation is in place: without it, the angle would be wrong by π/2 or the iterations would fail to converge. A zero denominator must give exactly ±π/4, and a zero numerator must give an exact zero rather than the sum of all table entries. The threshold is probed at |θ|, one above it and at zero, where an off-by-one comparison flips the skip decision. The skip path must return the elements bit-exact; a design that still applies its gain correction would show small drifts. Rotating pairs issued around a vectoring input that is still in flight show whether the angle is sampled at entry. Streamed column pairs are checked against a real-valued rotation and for orthogonality, which would expose a wrong rotation sense, a missing angle halving or a wrong gain constant.

// File: rtl/givrot_pkg.sv
package givrot_pkg;
    parameter int DW   = 18;             // data width at the ports
    parameter int ITER = 16;             // micro-rotation stages
    parameter int GB   = 3;              // fractional guard bits inside the datapath
    localparam int IW    = DW + 2 + GB;  // internal width: growth plus guard
    localparam int ZW    = 18;           // angle width, 2^-15 rad per unit
    localparam int KW    = 18;
    localparam int KFRAC = 17;
    localparam int LAT   = ITER + 2;
    // 1/K for the converged CORDIC gain, Q1.17
    localparam logic signed [KW-1:0] KINV = 18'sd79594;

    typedef struct packed {
        logic                 vld;
        logic                 vec;
        logic                 hold;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [ZW-1:0] z;
    } lane_t;

    typedef struct packed {
        logic                 vld;
        logic                 vec;
        logic signed [DW-1:0] a;
        logic signed [DW-1:0] b;
        logic signed [ZW-1:0] ang;
        logic                 rot;
    } res_t;

    // atan(2^-i) scaled by 2^15
    function automatic logic signed [ZW-1:0] atan_lut(input int i);
        case (i)
            0:  return ZW'(25736);
            1:  return ZW'(15193);
            2:  return ZW'(8027);
            3:  return ZW'(4075);
            4:  return ZW'(2045);
            5:  return ZW'(1024);
            6:  return ZW'(512);
            7:  return ZW'(256);
            8:  return ZW'(128);
            9:  return ZW'(64);
            10: return ZW'(32);
            11: return ZW'(16);
            12: return ZW'(8);
            13: return ZW'(4);
            14: return ZW'(2);
            15: return ZW'(1);
            default: return ZW'(0);
        endcase
    endfunction
endpackage

// File: rtl/givrot_pre.sv
module givrot_pre
    import givrot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_vec,
    input  logic signed [DW-1:0] in_a,
    input  logic signed [DW-1:0] in_b,
    input  logic signed [ZW-1:0] held_ang,
    input  logic                 held_rot,
    output lane_t                lane_o
);
    lane_t lane_d, lane_q;
    logic signed [IW-1:0] a_w, b_w;

    always_comb begin
        a_w = {{(IW-DW-GB){in_a[DW-1]}}, in_a, {GB{1'b0}}};
        b_w = {{(IW-DW-GB){in_b[DW-1]}}, in_b, {GB{1'b0}}};
        lane_d     = '0;
        lane_d.vld = in_valid;
        lane_d.vec = in_vec;
        if (in_vec) begin
            // fold the left half plane onto the right: atan(y/x) is unchanged
            lane_d.hold = (in_b == '0);
            lane_d.z    = '0;
            if (in_a[DW-1]) begin
                lane_d.x = -a_w;
                lane_d.y = -b_w;
            end else begin
                lane_d.x = a_w;
                lane_d.y = b_w;
            end
        end else begin
            lane_d.hold = !held_rot;
            lane_d.x    = a_w;
            lane_d.y    = b_w;
            lane_d.z    = held_ang;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign lane_o = lane_q;
endmodule

// File: rtl/givrot_stage.sv
module givrot_stage
    import givrot_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t lane_i,
    output lane_t lane_o
);
    lane_t lane_d, lane_q;
    logic signed [IW-1:0] xs, ys;
    logic signed [ZW-1:0] step;
    logic                 turn_neg;

    always_comb begin
        lane_d   = lane_i;
        xs       = $signed(lane_i.x) >>> IDX;
        ys       = $signed(lane_i.y) >>> IDX;
        step     = atan_lut(IDX);
        // vectoring drives y to zero, rotating drives z to zero
        turn_neg = lane_i.vec ? !lane_i.y[IW-1] : lane_i.z[ZW-1];
        if (!lane_i.hold) begin
            if (turn_neg) begin
                lane_d.x = lane_i.x + ys;
                lane_d.y = lane_i.y - xs;
                lane_d.z = lane_i.z + step;
            end else begin
                lane_d.x = lane_i.x - ys;
                lane_d.y = lane_i.y + xs;
                lane_d.z = lane_i.z - step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign lane_o = lane_q;
endmodule

// File: rtl/givrot_post.sv
module givrot_post
    import givrot_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  lane_t           lane_i,
    input  logic [ZW-2:0]   thresh,
    output res_t            res_o
);
    localparam int SH = KFRAC + GB;
    localparam logic signed [IW+KW-1:0] RND = (IW+KW)'(1) <<< (SH - 1);

    res_t res_d, res_q;
    logic signed [IW+KW-1:0] px, py;
    logic signed [ZW-1:0]    half;
    logic [ZW-1:0]           mag;

    always_comb begin
        px   = $signed(lane_i.x) * KINV;
        py   = $signed(lane_i.y) * KINV;
        half = $signed(lane_i.z) >>> 1;
        mag  = half[ZW-1] ? ZW'(-half) : ZW'(half);
        res_d     = res_q;
        res_d.vld = lane_i.vld;
        res_d.vec = lane_i.vec;
        if (lane_i.vld) begin
            if (lane_i.vec) begin
                res_d.a   = '0;
                res_d.b   = '0;
                res_d.ang = half;
                res_d.rot = (mag >= ZW'(thresh));
            end else if (lane_i.hold) begin
                res_d.a = DW'($signed(lane_i.x) >>> GB);
                res_d.b = DW'($signed(lane_i.y) >>> GB);
            end else begin
                res_d.a = DW'((px + RND) >>> SH);
                res_d.b = DW'((py + RND) >>> SH);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_o = res_q;
endmodule

// File: rtl/givrot_core.sv
module givrot_core
    import givrot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_vec,
    input  logic signed [DW-1:0] in_a,
    input  logic signed [DW-1:0] in_b,
    input  logic [ZW-2:0]        thresh,
    output logic                 out_valid,
    output logic                 out_vec,
    output logic signed [DW-1:0] out_a,
    output logic signed [DW-1:0] out_b,
    output logic signed [ZW-1:0] out_angle,
    output logic                 out_rot
);
    lane_t chain [0:ITER];
    res_t  res;

    givrot_pre u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_vec   (in_vec),
        .in_a     (in_a),
        .in_b     (in_b),
        .held_ang (res.ang),
        .held_rot (res.rot),
        .lane_o   (chain[0])
    );

    for (genvar g = 0; g < ITER; g++) begin : g_stage
        givrot_stage #(.IDX(g)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .lane_i (chain[g]),
            .lane_o (chain[g+1])
        );
    end

    givrot_post u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane_i (chain[ITER]),
        .thresh (thresh),
        .res_o  (res)
    );

    assign out_valid = res.vld;
    assign out_vec   = res.vec;
    assign out_a     = res.a;
    assign out_b     = res.b;
    assign out_angle = res.ang;
    assign out_rot   = res.rot;
endmodule

// File: rtl/givrot_core_chk.sv
module givrot_core_chk
    import givrot_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [ZW-2:0]        thresh,
    input logic                 out_valid,
    input logic                 out_vec,
    input logic signed [DW-1:0] out_a,
    input logic signed [DW-1:0] out_b,
    input logic signed [ZW-1:0] out_angle,
    input logic                 out_rot
);
    logic [15:0] inflight_q;

    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + 16'(in_valid) - 16'(out_valid);
    end

    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != 16'd0)); // R2

    AST_ANGLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_vec) |-> $stable(out_angle)); // R7

    AST_VEC_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_vec) |-> (out_a == '0 && out_b == '0)); // R7

    AST_ANGLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_vec) |-> (out_angle <= 18'sd25768 && out_angle >= -18'sd25768)); // R4

    AST_ZERO_THRESH_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_vec && thresh == '0) |-> out_rot); // R6

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_vec) |-> $stable(out_rot)); // R7
endmodule

bind givrot_core givrot_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .thresh    (thresh),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_angle (out_angle),
    .out_rot   (out_rot)
);

// File: tb/givrot_core_test.sv
module givrot_core_test;
    import givrot_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam real UNIT = 32768.0;
    localparam real PI = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_vec = 1'b0;
    logic signed [17:0] in_a = '0, in_b = '0;
    logic [16:0] thresh = '0;
    logic out_valid, out_vec, out_rot;
    logic signed [17:0] out_a, out_b, out_angle;

    givrot_core uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .in_a(in_a), .in_b(in_b), .thresh(thresh), .out_valid(out_valid),
        .out_vec(out_vec), .out_a(out_a), .out_b(out_b),
        .out_angle(out_angle), .out_rot(out_rot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;
    int cyc = 0;
    int iss_n = 0, cap_n = 0;
    int iss_cyc [0:511];
    int cap_cyc [0:511];
    int cap_a [0:511], cap_b [0:511], cap_ang [0:511];
    bit cap_vec [0:511], cap_rot [0:511];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 512) begin
            cap_a[cap_n] = out_a;  cap_b[cap_n] = out_b;
            cap_ang[cap_n] = out_angle; cap_vec[cap_n] = out_vec;
            cap_rot[cap_n] = out_rot;  cap_cyc[cap_n] = cyc;
            cap_n++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit vec, input int a, input int b);
        @(negedge clk);
        in_valid = 1'b1; in_vec = vec; in_a = 18'(a); in_b = 18'(b);
        iss_cyc[iss_n] = cyc; iss_n++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        wait (cap_n >= iss_n);
        @(negedge clk);
    endtask

    function automatic real ref_ang(input longint a, input longint b);
        if (b == 0) return 0.0;
        if (a == 0) return (b > 0 ? PI/4.0 : -PI/4.0) * UNIT;
        return 0.5 * $atan(real'(b) / real'(a)) * UNIT;
    endfunction

    function automatic longint absl(input longint v);
        return v < 0 ? -v : v;
    endfunction

    task automatic check_latency(input int k, input string req);
        chk(cap_cyc[k] - iss_cyc[k] == LAT, req, "latency", cap_cyc[k] - iss_cyc[k], LAT);
    endtask

    // vectoring evaluation; returns capture index
    task automatic eval_vec(input int a, input int b, input string req, output int k);
        longint e;
        k = iss_n;
        drive(1'b1, a, b);
        drain();
        e = longint'($rtoi(ref_ang(a, b) + (ref_ang(a, b) >= 0 ? 0.5 : -0.5)));
        chk(absl(cap_ang[k] - e) <= 16, req, "angle", cap_ang[k], e);
        check_latency(k, "R2");
        chk(cap_a[k] == 0 && cap_b[k] == 0, "R7", "vector data zero", cap_a[k] + cap_b[k], 0);
    endtask

    task automatic check_rot(input int k, input int a, input int b, input int ang, input string req);
        real th, ea, eb;
        th = real'(ang) / UNIT;
        ea = real'(a) * $cos(th) - real'(b) * $sin(th);
        eb = real'(a) * $sin(th) + real'(b) * $cos(th);
        chk(absl(cap_a[k] - longint'($rtoi(ea))) <= 6, req, "rotated a", cap_a[k], longint'($rtoi(ea)));
        chk(absl(cap_b[k] - longint'($rtoi(eb))) <= 6, req, "rotated b", cap_b[k], longint'($rtoi(eb)));
    endtask

    function automatic int rnd(input int span);
        return int'($urandom_range(0, 2*span)) - span;
    endfunction

    initial begin
        int k, k1, k2;
        int ang_a, ang_b;
        int col_i [0:7], col_j [0:7];
        int base;
        void'($urandom(32'd2718));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_rot == 0, "R1", "valid/flag in reset", {out_valid, out_rot}, 0);
        chk(out_angle == 0, "R1", "angle in reset", out_angle, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 0 && out_angle == 0 && out_rot == 0, "R1", "after reset", out_angle, 0);

        // R5: zero numerator gives exact zero
        thresh = '0;
        eval_vec(1000, 0, "R5", k);
        chk(cap_ang[k] == 0, "R5", "exact zero angle", cap_ang[k], 0);
        eval_vec(-5000, 0, "R5", k);
        chk(cap_ang[k] == 0, "R5", "exact zero angle neg", cap_ang[k], 0);
        chk(cap_rot[k] == 1, "R6", "zero thresh sets flag", cap_rot[k], 1);

        // R4: zero and negative denominators
        eval_vec(0, 3000, "R4", k);
        eval_vec(0, -3000, "R4", k);
        eval_vec(-20000, 15000, "R4", k);
        eval_vec(-70000, -90000, "R4", k);
        // R3: directed and random
        eval_vec(20000, 20000, "R3", k);
        for (int n = 0; n < 20; n++) begin
            int a, b;
            a = rnd(120000); b = rnd(120000);
            if (absl(a) < 4096 && absl(b) < 4096) a = 50000;
            eval_vec(a, b, "R3", k);
            chk(cap_rot[k] == 1, "R6", "zero thresh flag", cap_rot[k], 1);
        end

        // R6 / R9: threshold boundary and skip path
        eval_vec(20000, 20000, "R3", k);
        ang_a = cap_ang[k];
        thresh = 17'(ang_a);
        eval_vec(20000, 20000, "R6", k);
        chk(cap_rot[k] == 1, "R6", "thresh equal to angle rotates", cap_rot[k], 1);
        thresh = 17'(ang_a + 1);
        eval_vec(20000, 20000, "R6", k);
        chk(cap_rot[k] == 0, "R6", "thresh above angle skips", cap_rot[k], 0);
        base = iss_n;
        for (int n = 0; n < 6; n++) drive(1'b0, (n == 0) ? -131072 : rnd(131071), (n == 1) ? 131071 : rnd(131071));
        drain();
        for (int n = 0; n < 6; n++) begin
            chk(cap_a[base+n] == $signed(18'(n == 0 ? -131072 : 0)) || n != 0, "R9", "pass a min", cap_a[base+n], -131072);
            chk(cap_rot[base+n] == 0 && cap_ang[base+n] == ang_a, "R7", "held angle during skip", cap_ang[base+n], ang_a);
        end
        // exact pass-through for known values
        k = iss_n;
        drive(1'b0, 12345, -54321); drive(1'b0, -7, 99999);
        drain();
        chk(cap_a[k] == 12345 && cap_b[k] == -54321, "R9", "skip exact a", cap_a[k], 12345);
        chk(cap_a[k+1] == -7 && cap_b[k+1] == 99999, "R9", "skip exact b", cap_b[k+1], 99999);
        thresh = 17'(ang_a - 1000);
        eval_vec(20000, 20000, "R6", k);
        chk(cap_rot[k] == 1, "R6", "thresh below angle rotates", cap_rot[k], 1);

        // R8 / R10 / R2: column pairs streamed back to back
        thresh = '0;
        for (int t = 0; t < 4; t++) begin
            longint qi, qj, p, x, y, qi2, qj2, p2;
            real ratio;
            qi = 0; qj = 0; p = 0;
            for (int e = 0; e < 8; e++) begin
                col_i[e] = rnd(20000); col_j[e] = rnd(20000);
                qi += longint'(col_i[e]) * col_i[e];
                qj += longint'(col_j[e]) * col_j[e];
                p  += longint'(col_i[e]) * col_j[e];
            end
            x = qj - qi; y = 2 * p;
            while (absl(x) > 65535 || absl(y) > 65535) begin x = x >>> 1; y = y >>> 1; end
            eval_vec(int'(x), int'(y), "R3", k);
            ang_b = cap_ang[k];
            base = iss_n;
            for (int e = 0; e < 8; e++) drive(1'b0, col_i[e], col_j[e]);
            drain();
            qi2 = 0; qj2 = 0; p2 = 0;
            for (int e = 0; e < 8; e++) begin
                check_rot(base+e, col_i[e], col_j[e], ang_b, "R8");
                chk(cap_cyc[base+e] - iss_cyc[base+e] == LAT, "R2", "stream latency",
                    cap_cyc[base+e] - iss_cyc[base+e], LAT);
                qi2 += longint'(cap_a[base+e]) * cap_a[base+e];
                qj2 += longint'(cap_b[base+e]) * cap_b[base+e];
                p2  += longint'(cap_a[base+e]) * cap_b[base+e];
            end
            ratio = (real'(absl(p2)) / $sqrt(real'(qi2) * real'(qj2)));
            chk(ratio < 0.005, "R10", "orthogonality x1e6", longint'($rtoi(ratio * 1.0e6)), 5000);
        end

        // R11: angle sampled at entry
        eval_vec(30000, 10000, "R3", k);
        ang_a = cap_ang[k];
        k1 = iss_n;
        drive(1'b0, 10000, 20000);
        drive(1'b1, -30000, 25000);
        drive(1'b0, -15000, 5000);
        drain();
        ang_b = cap_ang[k1+1];
        chk(ang_b != ang_a, "R11", "second angle differs", ang_b, ang_a);
        check_rot(k1, 10000, 20000, ang_a, "R11");
        check_rot(k1+2, -15000, 5000, ang_a, "R11");
        k2 = iss_n;
        drive(1'b0, 8000, -9000);
        drain();
        check_rot(k2, 8000, -9000, ang_b, "R11");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule